// File: doc/BRIEF.md
# Parallel NOR Flash Write and Erase Sequencer

This block sits on the host side of a 16-bit asynchronous parallel NOR flash bus. A client asks for one of four operations (program one word, erase one sector, erase one block, erase the whole chip) over a request/acknowledge pair. The sequencer then issues the protective unlock writes and the command write as separate bus write cycles. After that it reads the device repeatedly until bit 6 of the read data stops alternating, and reports either completion or timeout.

Each write cycle holds chip enable low, presents address and data for a setup time, and pulses write enable low. The write-enable pulse width, setup, hold and read-access lengths are clock-count parameters. Each operation kind has its own polling limit, also a clock-count parameter. Bits 18..15 of every command-cycle address, and bits 15..8 of every command-cycle data word, are driven to zero.

Top module: `nor_seq`

## Requirements
- R1: When `req` is high while the block is idle, `ack` is high for exactly the following cycle, `busy` rises in that same cycle, and the request fields are captured. Operation codes: 0 = word program, 1 = sector erase, 2 = block erase, 3 = chip erase.
- R2: A word program issues exactly four writes in this order: 0x00AA to 0x05555, 0x0055 to 0x02AAA, 0x00A0 to 0x05555, then the request data to the request address.
- R3: Every erase issues exactly six writes. The first five are 0x00AA@0x05555, 0x0055@0x02AAA, 0x0080@0x05555, 0x00AA@0x05555 and 0x0055@0x02AAA. The sixth carries 0x0010 for chip erase, 0x0030 for sector erase and 0x0050 for block erase; for chip erase its address is 0x05555.
- R4: The sixth write's address is the request address with bits 10..0 cleared for a sector erase, and with bits 14..0 cleared for a block erase.
- R5: In every write cycle, chip enable is low and output enable is high. Address and data are driven for exactly SETUP_CLKS clocks before write enable falls. Write enable stays low for exactly PULSE_CLKS clocks. Chip enable, address and data are held for exactly HOLD_CLKS clocks after write enable rises. Address and data do not change while write enable is low.
- R6: No read cycle starts before the rising edge of the last write of the operation. Each read uses the address of that last write, drives output enable low with write enable high, and leaves the data bus undriven.
- R7: Once two consecutive reads show the same bit 6, the block makes two more reads. If those two agree in all 16 bits, it finishes with `done` set and `busy` low.
- R8: If the two confirming reads differ, polling resumes: the second of them becomes the new reference, and the toggle comparison runs again.
- R9: If the operation has not finished after its limit, it is aborted with `timeout` set and the bus released. The limit is PROG_LIMIT, ERASE_LIMIT or CHIP_LIMIT clocks, counted from the first read.
- R10: A request made while `busy` is high is neither acknowledged nor queued, and causes no bus cycles.
- R11: After reset, CE#, OE# and WE# are high, the data bus is undriven, and `ack`, `busy`, `done` and `timeout` are low. `done` and `timeout` stay set until the next accepted request, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Operation request |
| req_op | input | 2 | Operation code (see R1) |
| req_addr | input | 19 | Word address, sector or block address |
| req_data | input | 16 | Word to program |
| ack | output | 1 | One-cycle request acceptance |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation completed |
| timeout | output | 1 | Last operation hit its limit |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | 19 | Flash address bus |
| fl_dq_o | output | 16 | Data driven to the flash |
| fl_dq_oe | output | 1 | Drive enable for `fl_dq_o` |
| fl_dq_i | input | 16 | Data read from the flash |

## Verification
The embedded properties assume that `req` is a clean synchronous level. They also assume the flash returns a steady word on `fl_dq_i` throughout each output-enable window, and they place no constraint on which values it returns. The bench's flash model satisfies this: it advances its response only on the falling edge of output enable and holds it until the next read. It replays scripted read sequences: plain toggling, a spurious early match that forces the confirming pair to disagree, and endless toggling to reach each per-operation limit. New requests are driven only at falling clock edges, including the deliberate requests made while the block is busy.

// File: rtl/nor_seq.sv
module nor_seq #(
  parameter int SETUP_CLKS  = 2,
  parameter int PULSE_CLKS  = 3,
  parameter int HOLD_CLKS   = 2,
  parameter int READ_CLKS   = 4,
  parameter int PROG_LIMIT  = 1000,
  parameter int ERASE_LIMIT = 1600000,
  parameter int CHIP_LIMIT  = 6400000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [1:0]  req_op,
  input  logic [18:0] req_addr,
  input  logic [15:0] req_data,
  output logic        ack,
  output logic        busy,
  output logic        done,
  output logic        timeout,
  output logic        fl_ce_n,
  output logic        fl_oe_n,
  output logic        fl_we_n,
  output logic [18:0] fl_addr,
  output logic [15:0] fl_dq_o,
  output logic        fl_dq_oe,
  input  logic [15:0] fl_dq_i
);

  localparam int TA   = (SETUP_CLKS > PULSE_CLKS) ? SETUP_CLKS : PULSE_CLKS;
  localparam int TB   = (HOLD_CLKS > READ_CLKS) ? HOLD_CLKS : READ_CLKS;
  localparam int PW   = $clog2(((TA > TB) ? TA : TB) + 1);
  localparam int LA   = (PROG_LIMIT > ERASE_LIMIT) ? PROG_LIMIT : ERASE_LIMIT;
  localparam int LMAX = (LA > CHIP_LIMIT) ? LA : CHIP_LIMIT;
  localparam int TW   = $clog2(LMAX + 1);

  typedef enum logic [2:0] {IDLE, WSET, WLOW, WHOLD, WGAP, RD, RGAP} st_t;

  st_t st, st_n;
  logic [PW-1:0] tcnt, plen;
  logic [TW-1:0] tocnt, lim;
  logic [1:0]    op, pph;
  logic [18:0]   addr_q, s_addr;
  logic [15:0]   data_q, s_data, prev, vref;
  logic [2:0]    step;
  logic          last_step, phase_end, to_hit, ok_end;

  assign busy      = (st != IDLE);
  assign last_step = (op == 2'd0) ? (step == 3'd3) : (step == 3'd5);
  assign lim       = (op == 2'd0) ? TW'(PROG_LIMIT) :
                     (op == 2'd3) ? TW'(CHIP_LIMIT) : TW'(ERASE_LIMIT);
  assign phase_end = (tcnt == plen - 1'b1);
  assign to_hit    = (st == RD || st == RGAP) && (tocnt == lim - 1'b1);
  assign ok_end    = (st == RD) && phase_end && (pph == 2'd3) && (fl_dq_i == vref);
  assign fl_addr   = s_addr;
  assign fl_dq_o   = s_data;

  always_comb begin
    case (st)
      WSET:    plen = PW'(SETUP_CLKS);
      WLOW:    plen = PW'(PULSE_CLKS);
      WHOLD:   plen = PW'(HOLD_CLKS);
      RD:      plen = PW'(READ_CLKS);
      default: plen = PW'(1);
    endcase
  end

  always_comb begin
    s_addr = 19'h05555;
    s_data = 16'h00AA;
    case (step)
      3'd1, 3'd4: begin
        s_addr = 19'h02AAA;
        s_data = 16'h0055;
      end
      3'd2: s_data = (op == 2'd0) ? 16'h00A0 : 16'h0080;
      3'd3: if (op == 2'd0) begin
        s_addr = addr_q;
        s_data = data_q;
      end
      3'd5: case (op)
        2'd1: begin
          s_addr = {addr_q[18:11], 11'b0};
          s_data = 16'h0030;
        end
        2'd2: begin
          s_addr = {addr_q[18:15], 15'b0};
          s_data = 16'h0050;
        end
        default: s_data = 16'h0010;
      endcase
      default: ;
    endcase
  end

  always_comb begin
    st_n = st;
    case (st)
      IDLE:  if (req) st_n = WSET;
      WSET:  if (phase_end) st_n = WLOW;
      WLOW:  if (phase_end) st_n = WHOLD;
      WHOLD: if (phase_end) st_n = WGAP;
      WGAP:  st_n = last_step ? RD : WSET;
      RD:    if (to_hit || ok_end) st_n = IDLE;
             else if (phase_end) st_n = RGAP;
      RGAP:  st_n = to_hit ? IDLE : RD;
      default: st_n = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      tcnt <= '0;
      tocnt <= '0;
      op <= 2'd0;
      addr_q <= '0;
      data_q <= '0;
      step <= 3'd0;
      pph <= 2'd0;
      prev <= '0;
      vref <= '0;
      ack <= 1'b0;
      done <= 1'b0;
      timeout <= 1'b0;
      fl_ce_n <= 1'b1;
      fl_oe_n <= 1'b1;
      fl_we_n <= 1'b1;
      fl_dq_oe <= 1'b0;
    end else begin
      st <= st_n;
      tcnt <= (st_n != st) ? '0 : tcnt + 1'b1;
      ack <= (st == IDLE) && req;
      fl_ce_n <= !(st_n == WSET || st_n == WLOW || st_n == WHOLD || st_n == RD);
      fl_we_n <= (st_n != WLOW);
      fl_oe_n <= (st_n != RD);
      fl_dq_oe <= (st_n == WSET || st_n == WLOW || st_n == WHOLD);
      if (st == IDLE && req) begin
        op <= req_op;
        addr_q <= req_addr;
        data_q <= req_data;
        step <= 3'd0;
        done <= 1'b0;
        timeout <= 1'b0;
      end
      if (st == WGAP) begin
        if (last_step) begin
          tocnt <= '0;
          pph <= 2'd0;
        end else begin
          step <= step + 3'd1;
        end
      end
      if (st == RD || st == RGAP) tocnt <= tocnt + 1'b1;
      if (to_hit) timeout <= 1'b1;
      else if (st == RD && phase_end) begin
        case (pph)
          2'd0: begin
            prev <= fl_dq_i;
            pph <= 2'd1;
          end
          2'd1: if (fl_dq_i[6] != prev[6]) prev <= fl_dq_i;
                else pph <= 2'd2;
          2'd2: begin
            vref <= fl_dq_i;
            pph <= 2'd3;
          end
          default: if (fl_dq_i == vref) done <= 1'b1;
                   else begin
                     prev <= fl_dq_i;
                     pph <= 2'd1;
                   end
        endcase
      end
    end
  end

  p_ack_from_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(req) && !$past(busy));
  p_we_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> !fl_ce_n && fl_oe_n && fl_dq_oe);
  p_pulse_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> $stable(fl_addr) && $stable(fl_dq_o));
  p_hold_after_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> !fl_ce_n && fl_dq_oe && $stable(fl_addr) && $stable(fl_dq_o));
  p_read_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_ce_n && fl_we_n && !fl_dq_oe && last_step);
  p_done_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy && fl_oe_n && fl_ce_n);
  p_timeout_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> !busy && fl_ce_n && fl_oe_n);
  p_refuse_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req) |=> !ack);
  p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));

endmodule

// File: tb/sim_nor_seq.sv
module sim_nor_seq;
  localparam int SETUP = 2, PULSE = 3, HOLD = 2, READ = 3;
  localparam int LPROG = 150, LERASE = 300, LCHIP = 600;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic ack, busy, done, timeout, fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
  logic [18:0] fl_addr;
  logic [15:0] fl_dq_o, fl_dq_i, rd_val;

  int checks = 0, fails = 0, cyc = 0;
  int wcount = 0, rd_idx = 0, terr = 0, early = 0, acks = 0, exp_w = 0;
  int nscript = 0, lowlen = 0, setcnt = 0, holdcnt = 0, last_rise = 0;
  bit toggle_forever = 0, inhold = 0;
  logic [15:0] script [0:15];
  logic [18:0] wa [0:7];
  logic [15:0] wd [0:7];
  logic [18:0] fall_addr, rd_addr;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  nor_seq #(.SETUP_CLKS(SETUP), .PULSE_CLKS(PULSE), .HOLD_CLKS(HOLD), .READ_CLKS(READ),
            .PROG_LIMIT(LPROG), .ERASE_LIMIT(LERASE), .CHIP_LIMIT(LCHIP)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .ack(ack), .busy(busy), .done(done), .timeout(timeout),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_addr(fl_addr),
    .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i));

  always @* begin
    rd_val = 16'hFFFF;
    if (rd_idx > 0) begin
      if (rd_idx - 1 < nscript) rd_val = script[rd_idx - 1];
      else if (toggle_forever) rd_val = ((rd_idx - 1) % 2 == 1) ? 16'h0000 : 16'h0040;
      else if (nscript > 0) rd_val = script[nscript - 1];
    end
  end
  assign fl_dq_i = fl_oe_n ? 16'hFFFF : rd_val;

  always @(negedge fl_oe_n) begin
    rd_idx++;
    rd_addr = fl_addr;
    if (wcount != exp_w) early++;
  end
  always @(negedge fl_we_n) fall_addr = fl_addr;
  always @(posedge fl_we_n) if (rst_n) begin
    if (fl_addr != fall_addr) terr++;
    if (wcount < 8) begin
      wa[wcount] = fl_addr;
      wd[wcount] = fl_dq_o;
    end
    wcount++;
    last_rise = cyc;
  end

  always @(negedge clk) if (rst_n) begin
    if (ack) acks++;
    if (!fl_we_n) begin
      if (lowlen == 0 && setcnt != SETUP) terr++;
      lowlen++;
      setcnt = 0;
    end else begin
      if (lowlen != 0) begin
        if (lowlen != PULSE) terr++;
        lowlen = 0;
        inhold = 1;
        holdcnt = 0;
      end
      if (!fl_ce_n && fl_dq_oe) begin
        if (inhold) holdcnt++;
        else setcnt++;
      end else begin
        if (inhold && holdcnt != HOLD) terr++;
        inhold = 0;
        setcnt = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic clear_logs(input int nw);
    wcount = 0; rd_idx = 0; terr = 0; early = 0; acks = 0; exp_w = nw;
    toggle_forever = 0; nscript = 0;
  endtask

  task automatic start(input logic [1:0] op, input logic [18:0] a, input logic [15:0] d);
    @(negedge clk);
    req = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    chk(ack === 1'b1, "R1 ack after request", 32'(ack), 1);
    chk(busy === 1'b1, "R1 busy after accept", 32'(busy), 1);
    chk(done === 1'b0 && timeout === 1'b0, "R11 flags cleared on accept", {30'd0, done, timeout}, 0);
    req = 1'b0;
    @(negedge clk);
    chk(ack === 1'b0, "R1 ack one cycle", 32'(ack), 0);
  endtask

  task automatic wait_idle(output int endc);
    int n = 0;
    while (busy === 1'b1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    endc = cyc;
  endtask

  task automatic chk_write(input int i, input logic [18:0] a, input logic [15:0] d, input string rq);
    chk(wa[i] === a, rq, 32'(wa[i]), 32'(a));
    chk(wd[i] === d, rq, 32'(wd[i]), 32'(d));
  endtask

  task automatic chk_erase_prefix(input string rq);
    chk_write(0, 19'h05555, 16'h00AA, rq);
    chk_write(1, 19'h02AAA, 16'h0055, rq);
    chk_write(2, 19'h05555, 16'h0080, rq);
    chk_write(3, 19'h05555, 16'h00AA, rq);
    chk_write(4, 19'h02AAA, 16'h0055, rq);
  endtask

  task automatic t_reset;
    chk(fl_ce_n === 1'b1 && fl_oe_n === 1'b1 && fl_we_n === 1'b1, "R11 reset strobes high",
        {29'd0, fl_ce_n, fl_oe_n, fl_we_n}, 7);
    chk(fl_dq_oe === 1'b0, "R11 reset bus undriven", 32'(fl_dq_oe), 0);
    chk({ack, busy, done, timeout} === 4'b0, "R11 reset status low", {28'd0, ack, busy, done, timeout}, 0);
  endtask

  task automatic t_program;
    int e;
    clear_logs(4);
    script[0] = 16'h0040; script[1] = 16'h0000; script[2] = 16'h0040; script[3] = 16'h5AA5;
    nscript = 4;
    start(2'd0, 19'h61234, 16'hBEEF);
    repeat (4) @(negedge clk);
    req = 1'b1; req_op = 2'd3;
    repeat (10) @(negedge clk);
    req = 1'b0;
    wait_idle(e);
    chk(wcount == 4, "R2 program write count", wcount, 4);
    chk_write(0, 19'h05555, 16'h00AA, "R2 program write 1");
    chk_write(1, 19'h02AAA, 16'h0055, "R2 program write 2");
    chk_write(2, 19'h05555, 16'h00A0, "R2 program write 3");
    chk_write(3, 19'h61234, 16'hBEEF, "R2 program write 4");
    chk(terr == 0, "R5 write timing errors", terr, 0);
    chk(early == 0, "R6 read before last write", early, 0);
    chk(rd_addr === 19'h61234, "R6 poll address", 32'(rd_addr), 32'h61234);
    chk(done === 1'b1 && timeout === 1'b0, "R7 program done", {30'd0, done, timeout}, 2);
    chk(rd_idx == 7, "R7 read count", rd_idx, 7);
    repeat (30) @(negedge clk);
    chk(acks == 1, "R10 no ack while busy", acks, 1);
    chk(wcount == 4 && busy === 1'b0, "R10 busy request not queued", wcount, 4);
    chk(done === 1'b1, "R11 done sticky", 32'(done), 1);
  endtask

  task automatic t_sector;
    int e;
    clear_logs(6);
    script[0] = 16'h0040; script[1] = 16'h0000; script[2] = 16'hFFFF;
    nscript = 3;
    start(2'd1, 19'h53FFF, 16'h1111);
    wait_idle(e);
    chk(wcount == 6, "R3 sector write count", wcount, 6);
    chk_erase_prefix("R3 sector unlock");
    chk_write(5, 19'h53800, 16'h0030, "R4 sector final write");
    chk(terr == 0 && early == 0, "R5 R6 sector timing", terr + early, 0);
    chk(rd_addr === 19'h53800, "R6 sector poll address", 32'(rd_addr), 32'h53800);
    chk(done === 1'b1 && rd_idx == 6, "R7 sector done", rd_idx, 6);
  endtask

  task automatic t_block;
    int e;
    clear_logs(6);
    script[0] = 16'h0040; script[1] = 16'h0000; script[2] = 16'hFFFF;
    nscript = 3;
    start(2'd2, 19'h5BCDE, 16'h2222);
    wait_idle(e);
    chk(wcount == 6, "R3 block write count", wcount, 6);
    chk_erase_prefix("R3 block unlock");
    chk_write(5, 19'h58000, 16'h0050, "R4 block final write");
    chk(done === 1'b1 && rd_idx == 6, "R7 block done", rd_idx, 6);
  endtask

  task automatic t_chip_race;
    int e;
    clear_logs(6);
    script[0] = 16'h0040; script[1] = 16'h0000; script[2] = 16'h0000;
    script[3] = 16'h0040; script[4] = 16'h1234; script[5] = 16'h1234;
    nscript = 6;
    start(2'd3, 19'h7FFFF, 16'h3333);
    wait_idle(e);
    chk(wcount == 6, "R3 chip write count", wcount, 6);
    chk_erase_prefix("R3 chip unlock");
    chk_write(5, 19'h05555, 16'h0010, "R3 chip final write");
    chk(rd_addr === 19'h05555, "R6 chip poll address", 32'(rd_addr), 32'h05555);
    chk(rd_idx == 8, "R8 polling resumed after mismatch", rd_idx, 8);
    chk(done === 1'b1 && timeout === 1'b0, "R8 chip done", {30'd0, done, timeout}, 2);
  endtask

  task automatic t_timeout(input logic [1:0] op, input int lim, input string rq);
    int e, el;
    clear_logs(op == 2'd0 ? 4 : 6);
    toggle_forever = 1;
    start(op, 19'h00100, 16'h4444);
    wait_idle(e);
    el = e - last_rise;
    chk(timeout === 1'b1 && done === 1'b0, rq, {30'd0, done, timeout}, 1);
    chk(el >= lim && el <= lim + 8, {rq, " limit window"}, el, lim);
    chk(fl_ce_n === 1'b1 && fl_oe_n === 1'b1, "R9 bus released", {30'd0, fl_ce_n, fl_oe_n}, 3);
    repeat (20) @(negedge clk);
    chk(timeout === 1'b1, "R11 timeout sticky", 32'(timeout), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_program();
    t_sector();
    t_block();
    t_chip_race();
    t_timeout(2'd0, LPROG, "R9 program timeout");
    t_timeout(2'd3, LCHIP, "R9 chip timeout");
    t_timeout(2'd1, LERASE, "R9 sector timeout");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule